// File: doc/BRIEF.md
# Interrupt-Triggered Transfer Request Arbiter

This block sits between the interrupt request lines of the peripherals and a small data-transfer engine. Any line whose per-source enable bit is set becomes a transfer trigger. The block chooses one eligible line and hands its vector number to the engine with a start pulse. It then ignores every other request until the engine reports that this one transfer has finished. Priority is fixed: a lower vector number beats a higher one. The choice is made only when the block is idle. That happens at reset release, in the cycle after a completion, or once the global run bit has been switched on.

The engine answers each start with two pulses. An acknowledge pulse marks the moment data movement begins. It carries two flags: whether this is the final transfer of the programmed count, and whether this request should interrupt the CPU on every completion. A done pulse follows later. If neither flag is set, the block pulses a clear to the source's status flag when the acknowledge arrives, and the CPU is not interrupted. Otherwise the block forwards the interrupt to the CPU one cycle after done. On a final transfer it also drops the source's enable bit, so that line stops triggering transfers.

Top module: `xfer_req_arbiter`

## Requirements
- R1: A request line with its enable bit at 0 never produces a start pulse. Enable bits are set by a one-cycle pulse on `en_set[n]` and cleared by one on `en_clr[n]`.
- R2: Between a start pulse and the done pulse that closes that transfer, no further start pulse is issued, whatever the priority of newly raised requests.
- R3: When several enabled requests are pending as the block becomes idle, the start pulse carries the lowest pending vector number on `xfer_vec`.
- R4: While the run bit is 0, no start pulse is issued. The run bit is written with `run_val` while `run_wr` is 1. After it is written to 1, the start pulse appears two cycles after the write cycle. That pulse carries the lowest-numbered request that was pending and enabled at that moment.
- R5: An acknowledge with `xfer_last`=1 leads, one cycle after the matching done, to a single-cycle pulse on `cpu_irq[vec]`. The enable bit of that vector is also cleared, so the still-raised line triggers no further transfer.
- R6: An acknowledge with `xfer_isel`=1 and `xfer_last`=0 leads to a `cpu_irq[vec]` pulse one cycle after done. The enable bit is kept, so a still-raised line is granted again.
- R7: An acknowledge with both flags 0 produces a single-cycle pulse on `flag_clr[vec]` in the cycle after the acknowledge. No `cpu_irq` pulse follows that transfer.
- R8: Reset clears all enable bits and the run bit, and leaves `xfer_start`, `flag_clr` and `cpu_irq` at 0.
- R9: `cpu_irq` and `flag_clr` each have at most one bit set in any cycle, and that bit is the granted vector.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NVEC | Peripheral interrupt status lines, bit n is vector n |
| en_set | input | NVEC | Pulse to set the per-vector enable bits |
| en_clr | input | NVEC | Pulse to clear the per-vector enable bits |
| run_wr | input | 1 | Write strobe for the run bit |
| run_val | input | 1 | Value written to the run bit |
| xfer_start | output | 1 | One-cycle pulse that hands a request to the engine |
| xfer_vec | output | VW | Vector number of the granted request, held until the next start |
| xfer_ack | input | 1 | Engine pulse: data movement begins, flags are valid |
| xfer_last | input | 1 | With ack: the programmed count is exhausted by this transfer |
| xfer_isel | input | 1 | With ack: interrupt the CPU on every completion |
| xfer_done | input | 1 | Engine pulse: the transfer is complete |
| flag_clr | output | NVEC | One-cycle clear pulse to the source's status flag |
| cpu_irq | output | NVEC | One-cycle interrupt pulse forwarded to the CPU |

## Verification
The hardest situation to reach is a higher-priority request that appears while a lower-priority transfer is in progress. To show that nothing pre-empts the grant, the new request must arrive after the start pulse and before done. The bench gets there by playing the engine itself: it holds back acknowledge and done, raises a lower-numbered line in that gap, and watches for several cycles that no start pulse appears. It then checks that the new line wins only once done has arrived. The run-bit case is reached the same way. Requests are loaded while the run bit is 0, and the bench checks the first grant after the bit is written to 1.

// File: rtl/xfer_req_arbiter.sv
module xfer_req_arbiter #(
  parameter int NVEC = 32,
  localparam int VW = $clog2(NVEC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] irq_req,
  input  logic [NVEC-1:0] en_set,
  input  logic [NVEC-1:0] en_clr,
  input  logic            run_wr,
  input  logic            run_val,
  output logic            xfer_start,
  output logic [VW-1:0]   xfer_vec,
  input  logic            xfer_ack,
  input  logic            xfer_last,
  input  logic            xfer_isel,
  input  logic            xfer_done,
  output logic [NVEC-1:0] flag_clr,
  output logic [NVEC-1:0] cpu_irq
);

  typedef enum logic [1:0] {IDLE, WAIT_ACK, MOVE} state_t;

  state_t          state_q;
  logic [NVEC-1:0] en_q;
  logic            run_q;
  logic            last_q, isel_q;
  logic [NVEC-1:0] elig;
  logic [VW-1:0]   win;
  logic [NVEC-1:0] vec_oh;
  logic [NVEC-1:0] drop;

  assign elig   = irq_req & en_q;
  assign vec_oh = NVEC'(1) << xfer_vec;
  assign drop   = (state_q == MOVE && xfer_done && last_q) ? vec_oh : '0;

  always_comb begin
    win = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (elig[i]) win = VW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= IDLE;
      en_q       <= '0;
      run_q      <= 1'b0;
      last_q     <= 1'b0;
      isel_q     <= 1'b0;
      xfer_start <= 1'b0;
      xfer_vec   <= '0;
      flag_clr   <= '0;
      cpu_irq    <= '0;
    end else begin
      xfer_start <= 1'b0;
      flag_clr   <= '0;
      cpu_irq    <= '0;
      en_q       <= (en_q | en_set) & ~en_clr & ~drop;
      if (run_wr) run_q <= run_val;
      case (state_q)
        IDLE:
          if (run_q && |elig) begin
            xfer_start <= 1'b1;
            xfer_vec   <= win;
            state_q    <= WAIT_ACK;
          end
        WAIT_ACK:
          if (xfer_ack) begin
            last_q  <= xfer_last;
            isel_q  <= xfer_isel;
            if (!xfer_last && !xfer_isel) flag_clr <= vec_oh;
            state_q <= MOVE;
          end
        MOVE:
          if (xfer_done) begin
            if (last_q || isel_q) cpu_irq <= vec_oh;
            state_q <= IDLE;
          end
        default: state_q <= IDLE;
      endcase
    end
  end

  logic [NVEC-1:0] elig_prev;
  logic            run_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elig_prev <= '0;
      run_prev  <= 1'b0;
    end else begin
      elig_prev <= elig;
      run_prev  <= run_q;
    end
  end

  assert_start_enabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> elig_prev[xfer_vec]);
  assert_no_preempt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != IDLE && !xfer_done) |=> !xfer_start);
  assert_lowest_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (elig_prev & ((NVEC'(1) << xfer_vec) - NVEC'(1))) == '0);
  assert_held_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> run_prev);
  assert_last_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MOVE && xfer_done && last_q) |=> cpu_irq[xfer_vec] && !en_q[xfer_vec]);
  assert_isel_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MOVE && xfer_done && isel_q) |=> cpu_irq[xfer_vec]);
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WAIT_ACK && xfer_ack && !xfer_last && !xfer_isel) |=> flag_clr[xfer_vec]);
  assert_quiet_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MOVE && xfer_done && !last_q && !isel_q) |=> cpu_irq == '0);
  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cpu_irq) && $onehot0(flag_clr));

endmodule

// File: tb/test_xfer_req_arbiter.sv
module test_xfer_req_arbiter;
  localparam int NVEC = 32;
  localparam int VW = $clog2(NVEC);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NVEC-1:0] irq_req = '0, en_set = '0, en_clr = '0;
  logic            run_wr = 1'b0, run_val = 1'b0;
  logic            xfer_start;
  logic [VW-1:0]   xfer_vec;
  logic            xfer_ack = 1'b0, xfer_last = 1'b0, xfer_isel = 1'b0, xfer_done = 1'b0;
  logic [NVEC-1:0] flag_clr, cpu_irq;

  int n_chk = 0, n_bad = 0, cyc = 0;

  xfer_req_arbiter #(.NVEC(NVEC)) i_xfer_req_arbiter (
    .clk, .rst_n, .irq_req, .en_set, .en_clr, .run_wr, .run_val,
    .xfer_start, .xfer_vec, .xfer_ack, .xfer_last, .xfer_isel, .xfer_done,
    .flag_clr, .cpu_irq);

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic enable(int v);
    en_set[v] = 1'b1; tick(); en_set = '0;
  endtask

  task automatic set_run(logic v);
    run_wr = 1'b1; run_val = v; tick(); run_wr = 1'b0;
  endtask

  task automatic wait_start(int lim, output bit seen, output int vec);
    seen = 0; vec = -1;
    for (int i = 0; i < lim; i++) begin
      tick();
      if (xfer_start) begin seen = 1; vec = int'(xfer_vec); return; end
    end
  endtask

  // Ack then done; returns flag_clr and cpu_irq seen after each.
  task automatic finish_xfer(logic last, logic isel, bit drop_line,
                             output logic [NVEC-1:0] fc, output logic [NVEC-1:0] ci);
    int v;
    v = int'(xfer_vec);
    xfer_ack = 1'b1; xfer_last = last; xfer_isel = isel;
    tick();
    fc = flag_clr;
    xfer_ack = 1'b0; xfer_last = 1'b0; xfer_isel = 1'b0;
    if (fc[v]) irq_req[v] = 1'b0;
    xfer_done = 1'b1;
    tick();
    ci = cpu_irq;
    xfer_done = 1'b0;
    if (drop_line) irq_req[v] = 1'b0;
  endtask

  task automatic t_reset();
    bit s; int v;
    check("R8 start after reset", xfer_start, 0);
    check("R8 cpu_irq after reset", cpu_irq, 0);
    check("R8 flag_clr after reset", flag_clr, 0);
    irq_req = '1;
    set_run(1'b1);
    wait_start(8, s, v);
    check("R1/R8 no enable, no start", s, 0);
    irq_req = '0;
  endtask

  task automatic t_plain();
    bit s; int v; logic [NVEC-1:0] fc, ci;
    enable(5);
    irq_req[5] = 1'b1;
    wait_start(8, s, v);
    check("R1 enabled line starts", s, 1);
    check("R1 vector", v, 5);
    finish_xfer(1'b0, 1'b0, 1'b0, fc, ci);
    check("R7 flag clear pulse", fc, 32'h20);
    check("R7 no cpu irq", ci, 0);
    tick();
    check("R7 flag clear single cycle", flag_clr, 0);
    wait_start(5, s, v);
    check("R7 cleared line not regranted", s, 0);
  endtask

  task automatic t_priority();
    bit s; int v; logic [NVEC-1:0] fc, ci;
    set_run(1'b0);
    enable(3); enable(7); enable(20); enable(1);
    irq_req[7] = 1'b1; irq_req[20] = 1'b1;
    tick(); irq_req[3] = 1'b1;
    wait_start(6, s, v);
    check("R4 held while run is 0", s, 0);
    run_wr = 1'b1; run_val = 1'b1; tick(); run_wr = 1'b0;
    check("R4 no start one cycle after write", xfer_start, 0);
    tick();
    check("R4 start two cycles after write", xfer_start, 1);
    check("R4 highest priority at start", xfer_vec, 3);
    irq_req[1] = 1'b1;
    wait_start(6, s, v);
    check("R2 no pre-emption while busy", s, 0);
    finish_xfer(1'b0, 1'b0, 1'b0, fc, ci);
    wait_start(6, s, v);
    check("R3 lowest pending wins at completion", v, 1);
    finish_xfer(1'b0, 1'b0, 1'b0, fc, ci);
    check("R9 flag clear only granted vector", fc, 32'h2);
    wait_start(6, s, v);
    check("R3 next winner", v, 7);
    finish_xfer(1'b0, 1'b0, 1'b0, fc, ci);
    wait_start(6, s, v);
    check("R3 last winner", v, 20);
    finish_xfer(1'b0, 1'b0, 1'b0, fc, ci);
    wait_start(6, s, v);
    check("R3 queue empty", s, 0);
  endtask

  task automatic t_isel_last();
    bit s; int v; logic [NVEC-1:0] fc, ci;
    enable(12);
    irq_req[12] = 1'b1;
    wait_start(6, s, v);
    check("R6 start", v, 12);
    finish_xfer(1'b0, 1'b1, 1'b0, fc, ci);
    check("R6 no flag clear", fc, 0);
    check("R6 cpu irq pulse", ci, 32'h1000);
    tick();
    check("R6 cpu irq single cycle", cpu_irq, 0);
    check("R6 enable kept, regranted", xfer_start, 1);
    check("R6 regrant vector", xfer_vec, 12);
    finish_xfer(1'b1, 1'b0, 1'b0, fc, ci);
    check("R5 no flag clear", fc, 0);
    check("R5 cpu irq pulse", ci, 32'h1000);
    wait_start(8, s, v);
    check("R5 enable cleared, line idle", s, 0);
    enable(12);
    wait_start(6, s, v);
    check("R5 re-enabled line regranted", v, 12);
    finish_xfer(1'b1, 1'b1, 1'b1, fc, ci);
    check("R5 last with isel: one irq", ci, 32'h1000);
    en_clr[12] = 1'b1; tick(); en_clr = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_plain();
    t_priority();
    t_isel_last();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule